// File: doc/BRIEF.md
# Shadow Configuration Stager with Atomic Port Commit

This block is a second register window that sits beside a bank of pin-configuration ports. Each port has four bit-plane vectors: interrupt select, mask, pattern 1 and pattern 0. Software does not write these vectors in the live ports directly. It writes set and clear aliases in this window, and each write only accumulates into staged masks.

When software writes a port number to the commit register, every staged set and clear mask of all four vectors is sent to that port in the same clock cycle. The masks go out as one-cycle strobes into the live register files, which are outside this block. A pin therefore moves from one mode to another in a single step. It never passes through a mix of old and new bit-plane values, so the interrupt does not need to be masked around a mode change.

A typical sequence stages a high-level interrupt in three writes: set the interrupt-select bit, clear the pattern 1 bit and set the pattern 0 bit. A fourth write, of the port number to the commit register, then applies all three.

Top module: `shadow_cfg_stager`

## Requirements
- R1: After reset no strobe is high, every output mask is zero and every staged mask is empty, so a first commit delivers all-zero masks.
- R2: A write to a set alias ORs the data into that vector's staged set mask and removes the same bits from its staged clear mask. A write to a clear alias does the reverse, so the later write wins for any bit. The aliases, as set/clear offsets, are: interrupt select 0x014/0x018 (vector 0), mask 0x024/0x028 (vector 1), pattern 1 0x034/0x038 (vector 2), pattern 0 0x044/0x048 (vector 3).
- R3: Writing a value P below NUM_PORTS to offset 0x0F0 makes all four set strobes and all four clear strobes of port P high in the cycle after that write, for that one cycle only. Each strobe carries the staged mask of its vector. A strobe is high even when its mask is zero. Strobe index is P*4+v and mask slice is (P*4+v)*DATA_W.
- R4: Strobes of at most one port are high in any cycle. While a strobe is low, its mask output is zero.
- R5: After a valid commit, every staged set and clear mask returns to zero.
- R6: A commit value of NUM_PORTS or more, including values with upper bits set, raises no strobe and leaves the staged masks unchanged.
- R7: A write to any other offset has no effect. This covers unaligned offsets, the read-only and live-only offsets, and offsets that differ only above bit 7.
- R8: Staging in one vector does not alter the staged masks of any other vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset within the shadow window |
| wr_data | input | DATA_W | Write data |
| set_stb | output | NUM_PORTS*4 | Set strobe per port and vector |
| set_mask | output | NUM_PORTS*4*DATA_W | Bits to set, per port and vector |
| clr_stb | output | NUM_PORTS*4 | Clear strobe per port and vector |
| clr_mask | output | NUM_PORTS*4*DATA_W | Bits to clear, per port and vector |

## Verification
Staged state in this block is hidden until a commit, so a corrupted staged bit shows up only at the next commit. It then appears as a wrong set or clear mask on the chosen port, exactly one cycle after the commit write. The bench therefore follows every staging sequence with a commit and compares all ports' strobes and masks against an arithmetic model in that cycle and the cycle after. Ignored writes and rejected commits are exposed the same way, by a later valid commit whose masks must be unchanged.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;
   localparam int NUM_VEC = 4;

   typedef enum logic [1:0] {
      VEC_INTSEL = 2'd0,
      VEC_MASK   = 2'd1,
      VEC_PAT1   = 2'd2,
      VEC_PAT0   = 2'd3
   } vec_e;

   localparam logic [7:0] COMMIT_OFF = 8'hF0;

   // Relative offsets of the set and clear aliases; vector v sits at 0x10*(v+1).
   function automatic logic [7:0] set_off(input int v);
      return 8'(8'h14 + 8'(v) * 8'h10);
   endfunction

   function automatic logic [7:0] clr_off(input int v);
      return 8'(8'h18 + 8'(v) * 8'h10);
   endfunction
endpackage

// File: rtl/shadow_decode.sv
module shadow_decode
   import shadow_cfg_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int NUM_PORTS = 4,
   localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [NUM_VEC-1:0]  set_hit,
   output logic [NUM_VEC-1:0]  clr_hit,
   output logic                commit_ok,
   output logic                commit_bad,
   output logic [PORT_W-1:0]   commit_port
);
   logic upper_zero;
   logic commit_hit;
   logic port_in_range;

   generate
      if (ADDR_W > 8) begin : g_upper
         assign upper_zero = (wr_addr[ADDR_W-1:8] == '0);
      end else begin : g_no_upper
         assign upper_zero = 1'b1;
      end
   endgenerate

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      assign set_hit[v] = wr_en && upper_zero && (wr_addr[7:0] == set_off(v));
      assign clr_hit[v] = wr_en && upper_zero && (wr_addr[7:0] == clr_off(v));
   end

   assign commit_hit    = wr_en && upper_zero && (wr_addr[7:0] == COMMIT_OFF);
   assign port_in_range = (wr_data < DATA_W'(NUM_PORTS));
   assign commit_ok     = commit_hit && port_in_range;
   assign commit_bad    = commit_hit && !port_in_range;
   assign commit_port   = wr_data[PORT_W-1:0];

   // R7: at most one alias or the commit register is decoded per write
   assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({set_hit, clr_hit, commit_ok, commit_bad}) <= 1);
endmodule

// File: rtl/shadow_stage.sv
module shadow_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_hit,
   input  logic              clr_hit,
   input  logic              wipe,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] set_q,
   output logic [DATA_W-1:0] clr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         set_q <= '0;
         clr_q <= '0;
      end else if (wipe) begin
         set_q <= '0;
         clr_q <= '0;
      end else if (set_hit) begin
         set_q <= set_q | wr_data;
         clr_q <= clr_q & ~wr_data;
      end else if (clr_hit) begin
         clr_q <= clr_q | wr_data;
         set_q <= set_q & ~wr_data;
      end
   end

   // R2: a bit is never staged for both set and clear
   assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_q & clr_q) == '0);

   // R5: a wipe empties both planes
   assert_wipe_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> (set_q == '0) && (clr_q == '0));

   // R8: without a hit or wipe this vector holds its state
   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_hit || clr_hit || wipe) |=> $stable(set_q) && $stable(clr_q));
endmodule

// File: rtl/shadow_commit_port.sv
module shadow_commit_port #(
   parameter int DATA_W  = 32,
   parameter int NUM_VEC = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fire,
   input  logic [NUM_VEC*DATA_W-1:0] staged_set,
   input  logic [NUM_VEC*DATA_W-1:0] staged_clr,
   output logic [NUM_VEC-1:0]        set_stb,
   output logic [NUM_VEC*DATA_W-1:0] set_mask,
   output logic [NUM_VEC-1:0]        clr_stb,
   output logic [NUM_VEC*DATA_W-1:0] clr_mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         set_stb  <= '0;
         clr_stb  <= '0;
         set_mask <= '0;
         clr_mask <= '0;
      end else if (fire) begin
         set_stb  <= '1;
         clr_stb  <= '1;
         set_mask <= staged_set;
         clr_mask <= staged_clr;
      end else begin
         set_stb  <= '0;
         clr_stb  <= '0;
         set_mask <= '0;
         clr_mask <= '0;
      end
   end

   // R3: strobes only follow a commit addressed to this port
   assert_stb_after_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb != '0) |-> $past(fire));

   // R3: all planes of the port move together
   assert_planes_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb == '0 || set_stb == '1) && (clr_stb == set_stb));

   // R4: an idle strobe carries no mask
   assert_idle_mask_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb == '0) |-> (set_mask == '0) && (clr_mask == '0));
endmodule

// File: rtl/shadow_cfg_stager.sv
module shadow_cfg_stager
   import shadow_cfg_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int NUM_PORTS = 4,
   localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int NSTB     = NUM_PORTS * NUM_VEC
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [NSTB-1:0]          set_stb,
   output logic [NSTB*DATA_W-1:0]   set_mask,
   output logic [NSTB-1:0]          clr_stb,
   output logic [NSTB*DATA_W-1:0]   clr_mask
);
   initial begin
      if (ADDR_W < 8) $error("ADDR_W must cover the 0xF0 commit offset");
      if (DATA_W < 8 || DATA_W > 32) $error("DATA_W must be 8..32");
      if (NUM_PORTS < 1 || NUM_PORTS > 64) $error("NUM_PORTS must be 1..64");
   end

   logic [NUM_VEC-1:0]        set_hit, clr_hit;
   logic                      commit_ok, commit_bad;
   logic [PORT_W-1:0]         commit_port;
   logic [NUM_VEC*DATA_W-1:0] staged_set, staged_clr;
   logic [NUM_PORTS-1:0]      port_live;

   shadow_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .set_hit(set_hit), .clr_hit(clr_hit),
      .commit_ok(commit_ok), .commit_bad(commit_bad), .commit_port(commit_port)
   );

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_stage
      shadow_stage #(.DATA_W(DATA_W)) u_stage (
         .clk(clk), .rst_n(rst_n),
         .set_hit(set_hit[v]), .clr_hit(clr_hit[v]), .wipe(commit_ok),
         .wr_data(wr_data),
         .set_q(staged_set[v*DATA_W +: DATA_W]),
         .clr_q(staged_clr[v*DATA_W +: DATA_W])
      );
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      shadow_commit_port #(.DATA_W(DATA_W), .NUM_VEC(NUM_VEC)) u_port (
         .clk(clk), .rst_n(rst_n),
         .fire(commit_ok && (commit_port == PORT_W'(p))),
         .staged_set(staged_set), .staged_clr(staged_clr),
         .set_stb(set_stb[p*NUM_VEC +: NUM_VEC]),
         .set_mask(set_mask[p*NUM_VEC*DATA_W +: NUM_VEC*DATA_W]),
         .clr_stb(clr_stb[p*NUM_VEC +: NUM_VEC]),
         .clr_mask(clr_mask[p*NUM_VEC*DATA_W +: NUM_VEC*DATA_W])
      );
      assign port_live[p] = set_stb[p*NUM_VEC];
   end

   // R4: strobes of at most one port per cycle
   assert_single_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(port_live));

   // R3: a valid commit produces a strobe in the next cycle
   assert_commit_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit_ok |=> (port_live != '0));

   // R6: a rejected commit keeps staging and raises nothing
   assert_bad_commit_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit_bad |=> $stable(staged_set) && $stable(staged_clr) && (set_stb == '0));
endmodule

// File: tb/tb_shadow_cfg_stager.sv
module tb_shadow_cfg_stager;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam int NP = 4;
   localparam int NV = 4;
   localparam int NS = NP * NV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [NS-1:0] set_stb, clr_stb;
   logic [NS*DW-1:0] set_mask, clr_mask;

   int n_tests = 0;
   int n_fail  = 0;
   logic [DW-1:0] m_set [NV];
   logic [DW-1:0] m_clr [NV];

   always #10 clk = ~clk;

   shadow_cfg_stager #(.ADDR_W(AW), .DATA_W(DW), .NUM_PORTS(NP)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .set_stb(set_stb), .set_mask(set_mask),
      .clr_stb(clr_stb), .clr_mask(clr_mask)
   );

   initial begin
      #4_000_000;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish (got hang, expected completion)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Alias offsets per R2: set 0x14+0x10*v, clear 0x18+0x10*v.
   task automatic stage(input int v, input bit is_clr, input logic [DW-1:0] d);
      bus_wr(is_clr ? AW'(12'h018 + 16*v) : AW'(12'h014 + 16*v), d);
      if (is_clr) begin
         m_clr[v] = m_clr[v] | d; m_set[v] = m_set[v] & ~d;
      end else begin
         m_set[v] = m_set[v] | d; m_clr[v] = m_clr[v] & ~d;
      end
   endtask

   // port < 0 means no strobe expected anywhere
   task automatic check_out(input int port, input string req);
      logic [NS-1:0] e_stb;
      logic [NS*DW-1:0] e_set, e_clr;
      e_stb = '0; e_set = '0; e_clr = '0;
      if (port >= 0) begin
         for (int v = 0; v < NV; v++) begin
            e_stb[port*NV+v] = 1'b1;
            e_set[(port*NV+v)*DW +: DW] = m_set[v];
            e_clr[(port*NV+v)*DW +: DW] = m_clr[v];
         end
      end
      n_tests++;
      if (set_stb !== e_stb || clr_stb !== e_stb) begin
         n_fail++;
         $display("FAIL %s strobes: got set=%h clr=%h expected %h", req, set_stb, clr_stb, e_stb);
      end else if (set_mask !== e_set || clr_mask !== e_clr) begin
         n_fail++;
         $display("FAIL %s masks: got set=%h clr=%h expected set=%h clr=%h",
                  req, set_mask, clr_mask, e_set, e_clr);
      end
   endtask

   task automatic commit(input int port, input string req);
      bus_wr(AW'(12'h0F0), DW'(port));
      check_out(port, req);
      for (int v = 0; v < NV; v++) begin m_set[v] = '0; m_clr[v] = '0; end
      @(negedge clk);
      check_out(-1, {req, " one-cycle"});
   endtask

   initial begin
      for (int v = 0; v < NV; v++) begin m_set[v] = '0; m_clr[v] = '0; end
      repeat (3) @(negedge clk);
      check_out(-1, "R1 reset idle");
      rst_n = 1'b1;
      @(negedge clk);
      check_out(-1, "R1 after reset");
      commit(0, "R1 empty commit");

      // R3/R8: sweep ports, vectors and arithmetic patterns
      for (int p = 0; p < NP; p++) begin
         for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < 3; i++) begin
               logic [DW-1:0] a, b;
               a = DW'(32'h9E37_79B9 * (i + 1 + p * 7 + v * 3));
               b = DW'(32'h0F0F_3C3C ^ (a << (i + 1)));
               stage(v, 1'b0, a);
               stage(v, 1'b1, b);
               stage((v + 1) % NV, i[0], a ^ b);
            end
            commit(p, "R3 R8 sweep");
         end
      end

      // R2: later write wins for the same bit
      stage(1, 1'b0, 32'h0000_00FF);
      stage(1, 1'b1, 32'h0000_000F);
      stage(1, 1'b0, 32'h0000_0001);
      commit(2, "R2 later write wins");

      // R2: high-level interrupt sequence on one pin
      stage(0, 1'b0, 32'h0000_0020);
      stage(2, 1'b1, 32'h0000_0020);
      stage(3, 1'b0, 32'h0000_0020);
      commit(1, "R2 level-high sequence");

      // R6: out-of-range commits are ignored and staging survives
      stage(3, 1'b1, 32'hA5A5_0000);
      foreach (m_set[k]) ; // no-op, keeps model
      begin
         logic [DW-1:0] bad [3];
         bad[0] = DW'(NP); bad[1] = DW'(NP + 1); bad[2] = 32'hFFFF_FFFF;
         for (int j = 0; j < 3; j++) begin
            bus_wr(AW'(12'h0F0), bad[j]);
            check_out(-1, "R6 bad commit no strobe");
         end
      end
      bus_wr(AW'(12'h0F0), 32'h0001_0002);
      check_out(-1, "R6 upper bits set");
      commit(3, "R6 staging kept");

      // R5: staging empty after commit
      stage(2, 1'b0, 32'h1234_5678);
      commit(0, "R5 first");
      commit(0, "R5 empty after commit");

      // R7: writes to other offsets have no effect
      stage(0, 1'b0, 32'h0000_0C00);
      begin
         logic [AW-1:0] other [8];
         other[0] = 12'h000; other[1] = 12'h010; other[2] = 12'h020;
         other[3] = 12'h050; other[4] = 12'h058; other[5] = 12'h016;
         other[6] = 12'h114; other[7] = 12'h1F0;
         for (int j = 0; j < 8; j++) begin
            bus_wr(other[j], 32'hFFFF_FFFF);
            check_out(-1, "R7 stray write");
         end
      end
      commit(1, "R7 staging unchanged");

      // R4: back-to-back commits, one port at a time
      stage(1, 1'b0, 32'h8000_0000);
      bus_wr(AW'(12'h0F0), 32'd2);
      check_out(2, "R4 first of pair");
      for (int v = 0; v < NV; v++) begin m_set[v] = '0; m_clr[v] = '0; end
      bus_wr(AW'(12'h0F0), 32'd3);
      check_out(3, "R4 second of pair");

      @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule